// File: doc/BRIEF.md
# Display Status Interrupt Line Generator

This block builds the display-status interrupt request of a tile-based handheld video unit. It watches the current video mode (0 horizontal blank, 1 vertical blank, 2 object search, 3 pixel drawing), a line-compare coincidence flag and the display-enable bit. Each of the four conditions can be enabled through a status/enable byte that software writes. Every enabled condition that is currently true feeds a single shared internal line, and that line is evaluated on every clock.

The CPU interrupt-flag register receives a one-cycle request only when this shared line goes from low to high. While the line stays high, a second condition that becomes true raises no new request. Software can therefore arrange for overlapping conditions to block each other.

The block also models a quirk of the older monochrome model. On that model, a write to the status byte while the display is on and the unit is in vertical blank looks, for one cycle, as if every source were enabled. This can inject an unexpected request. A model-select input turns the quirk off, and a second input extends it to horizontal blank.

Top module: `stat_irq_gen`

## Requirements
- R1: After reset, `irq_req_o` is low, all four source enables are clear and the internal line is low.
- R2: A write stores data bits 3 (horizontal blank), 4 (vertical blank), 5 (object search) and 6 (coincidence) as enables, which read back at the same positions on `stat_rd_o`. The other bits of the readback are fixed: bits 1:0 always show `mode_i`, bit 2 always shows `coinc_i`, and bit 7 always reads 0. Data bits 0 to 2 and bit 7 of a write are ignored.
- R3: Each mode source is active exactly when `mode_i` equals its mode number. The coincidence source is active while `coinc_i` is high.
- R4: The internal line is the OR of all sources that are both enabled and active. A 0-to-1 change of the line produces `irq_req_o` high for exactly one cycle, on the clock after the inputs that cause it. A source that is active but not enabled produces nothing.
- R5: While the line is high, further sources that become active produce no request.
- R6: With all four enables set (write 0x78), only mode 3 with coincidence low drops the line. If coincidence is high before mode 3 and stays high, later mode changes produce no request.
- R7: While `disp_en_i` is low, the line is held low and no request is produced. Turning the display on with an enabled source active produces one request.
- R8: With `quirk_en_i` high, `disp_en_i` high and mode 1, any write to the status byte (0x00 included) evaluates the line for that cycle as if all four enables were set. If the line was low, a request results.
- R9: A spurious write produces no request when the line is already high.
- R10: In mode 0, the spurious write applies only while `quirk_hblank_i` is high. In modes 2 and 3 it never applies.
- R11: With `quirk_en_i` low, a write never produces a spurious request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Current video mode (0..3) |
| coinc_i | input | 1 | Line-compare coincidence flag |
| disp_en_i | input | 1 | Display enabled |
| wr_en_i | input | 1 | Write strobe for the status/enable byte |
| wr_data_i | input | 8 | Write data |
| quirk_en_i | input | 1 | Monochrome-model quirk enable |
| quirk_hblank_i | input | 1 | Quirk also applies in mode 0 |
| stat_rd_o | output | 8 | Status/enable byte readback |
| irq_req_o | output | 1 | One-cycle interrupt request |

## Verification
Each source is first enabled on its own and driven into its active condition. This shows that the mode decode and the enable positions are matched correctly, and that an active but disabled source stays silent. Next, several enables are set together and the mode walks through its sequence, with coincidence either low or held high. A request on every mode change would reveal level triggering. A request that never returns after mode 3 would reveal a line that fails to drop. Finally, status writes are issued under every combination of quirk enable, horizontal-blank option, mode and prior line level. This separates a correct one-cycle forced evaluation from a quirk that ignores blocking or that fires in the wrong mode.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int REG_W   = 8;
  localparam int EN_LSB  = 3;

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_OAM    = 2'd2,
    MODE_DRAW   = 2'd3
  } vmode_e;

  localparam int SRC_HBL = 0;
  localparam int SRC_VBL = 1;
  localparam int SRC_OAM = 2;
  localparam int SRC_LYC = 3;
endpackage

// File: rtl/stat_en_reg.sv
module stat_en_reg #(
  parameter int NUM_SRC = stat_irq_pkg::NUM_SRC,
  parameter int REG_W   = stat_irq_pkg::REG_W,
  parameter int EN_LSB  = stat_irq_pkg::EN_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [NUM_SRC-1:0] en_o
);
  localparam int EN_MSB = EN_LSB + NUM_SRC - 1;

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;

  // Only the enable field is writable; the remaining bits are read-only.
  always_comb begin
    en_d = en_q;
    if (wr_en_i) en_d = wr_data_i[EN_MSB:EN_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/stat_src_eval.sv
module stat_src_eval #(
  parameter int NUM_SRC = stat_irq_pkg::NUM_SRC
) (
  input  logic [1:0]         mode_i,
  input  logic               coinc_i,
  input  logic               disp_en_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               line_o
);
  localparam int NUM_MODE_SRC = NUM_SRC - 1;

  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] hit;

  // Mode sources 0..2 are decoded from the mode number; the last is coincidence.
  for (genvar i = 0; i < NUM_MODE_SRC; i++) begin : g_mode_src
    assign active[i] = (mode_i == 2'(i));
  end
  assign active[NUM_SRC-1] = coinc_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = active[i] & mask_i[i];
  end

  assign line_o = disp_en_i & (|hit);
endmodule

// File: rtl/stat_edge_pulse.sv
module stat_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic line_d_i,
  output logic line_q_o,
  output logic pulse_o
);
  logic line_q;
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = line_d_i & ~line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      line_q  <= line_d_i;
      pulse_q <= pulse_d;
    end
  end

  assign line_q_o = line_q;
  assign pulse_o  = pulse_q;
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen
  import stat_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int RW   = REG_W,
  parameter int ELSB = EN_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          coinc_i,
  input  logic          disp_en_i,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_data_i,
  input  logic          quirk_en_i,
  input  logic          quirk_hblank_i,
  output logic [RW-1:0] stat_rd_o,
  output logic          irq_req_o
);
  localparam int PAD_W = RW - ELSB - NSRC;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] eval_mask;
  logic            quirk_fire;
  logic            line_nxt;
  logic            line_q;

  stat_en_reg #(.NUM_SRC(NSRC), .REG_W(RW), .EN_LSB(ELSB)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_q)
  );

  // Legacy write quirk: for the write cycle, evaluate as if every source were enabled.
  always_comb begin
    quirk_fire = wr_en_i & quirk_en_i & disp_en_i &
                 ((mode_i == MODE_VBLANK) |
                  (quirk_hblank_i & (mode_i == MODE_HBLANK)));
    eval_mask  = quirk_fire ? {NSRC{1'b1}} : en_q;
  end

  stat_src_eval #(.NUM_SRC(NSRC)) u_eval (
    .mode_i    (mode_i),
    .coinc_i   (coinc_i),
    .disp_en_i (disp_en_i),
    .mask_i    (eval_mask),
    .line_o    (line_nxt)
  );

  stat_edge_pulse u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_d_i (line_nxt),
    .line_q_o (line_q),
    .pulse_o  (irq_req_o)
  );

  assign stat_rd_o = {{PAD_W{1'b0}}, en_q, coinc_i, mode_i};
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       disp_en_i,
  input logic       wr_en_i,
  input logic [7:0] stat_rd_o,
  input logic       irq_req_o,
  input logic       line_q
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |=> !irq_req_o);

  assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (line_q && !$past(line_q)));

  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |=> !irq_req_o);

  assert_disp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en_i |=> (!line_q && !irq_req_o));

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(stat_rd_o[6:3]));
endmodule

bind stat_irq_gen stat_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_en_i (disp_en_i),
  .wr_en_i   (wr_en_i),
  .stat_rd_o (stat_rd_o),
  .irq_req_o (irq_req_o),
  .line_q    (line_q)
);

// File: tb/stat_irq_gen_test.sv
module stat_irq_gen_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       coinc_i;
  logic       disp_en_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic       quirk_en_i;
  logic       quirk_hblank_i;
  logic [7:0] stat_rd_o;
  logic       irq_req_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  stat_irq_gen uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Pulse counter samples away from the active edge.
  always @(negedge clk) if (rst_n && irq_req_o) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  // Write the status byte for one cycle and return the pulses seen over n cycles.
  task automatic wr_count(input logic [7:0] d, input int n, output int cnt);
    int p0;
    p0 = pulses;
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
    step(n - 1);
    cnt = pulses - p0;
  endtask

  task automatic set_en(input logic [7:0] d);
    logic save;
    save = disp_en_i;
    disp_en_i = 1'b0;
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
    step();
    disp_en_i = save;
  endtask

  task automatic t_reset;
    chk(irq_req_o == 1'b0, "R1 irq after reset", irq_req_o, 0);
    chk(stat_rd_o == 8'h00, "R1 readback after reset", stat_rd_o, 8'h00);
  endtask

  task automatic t_readback;
    mode_i = 2'd2; coinc_i = 1'b1; disp_en_i = 1'b0;
    set_en(8'hFF);
    chk(stat_rd_o == 8'h7E, "R2 readback after 0xFF", stat_rd_o, 8'h7E);
    set_en(8'h87);
    chk(stat_rd_o == 8'h06, "R2 ro bits ignored", stat_rd_o, 8'h06);
    mode_i = 2'd1; coinc_i = 1'b0; step();
    chk(stat_rd_o == 8'h01, "R2 live mode bits", stat_rd_o, 8'h01);
  endtask

  task automatic t_single_sources;
    int p0;
    quirk_en_i = 1'b0; coinc_i = 1'b0;
    mode_i = 2'd3; set_en(8'h08); disp_en_i = 1'b1; step(2);
    mode_i = 2'd0; step();
    chk(irq_req_o == 1'b1, "R3 hblank pulse timing", irq_req_o, 1);
    step();
    chk(irq_req_o == 1'b0, "R4 pulse one cycle", irq_req_o, 0);
    p0 = pulses; mode_i = 2'd1; step(3);
    chk(pulses - p0 == 0, "R4 disabled source silent", pulses - p0, 0);
    mode_i = 2'd3; set_en(8'h40); disp_en_i = 1'b1; step(2);
    p0 = pulses; coinc_i = 1'b1; step(3);
    chk(pulses - p0 == 1, "R3 coincidence source", pulses - p0, 1);
    coinc_i = 1'b0;
    mode_i = 2'd3; set_en(8'h20); disp_en_i = 1'b1; step(2);
    p0 = pulses; mode_i = 2'd2; step(3);
    chk(pulses - p0 == 1, "R3 oam source", pulses - p0, 1);
  endtask

  task automatic t_blocking;
    int p0;
    mode_i = 2'd3; coinc_i = 1'b0; set_en(8'h30); disp_en_i = 1'b1; step(2);
    p0 = pulses; mode_i = 2'd1; step(2);
    chk(pulses - p0 == 1, "R4 vblank rise", pulses - p0, 1);
    p0 = pulses; mode_i = 2'd2; step(3);
    chk(pulses - p0 == 0, "R5 oam blocked by held line", pulses - p0, 0);
  endtask

  task automatic t_all_enabled;
    int p0;
    mode_i = 2'd3; coinc_i = 1'b0; set_en(8'h78); disp_en_i = 1'b1; step(2);
    p0 = pulses;
    mode_i = 2'd0; step(2); mode_i = 2'd1; step(2); mode_i = 2'd2; step(2);
    chk(pulses - p0 == 1, "R6 one pulse through 0,1,2", pulses - p0, 1);
    p0 = pulses; mode_i = 2'd3; step(2); mode_i = 2'd0; step(2);
    chk(pulses - p0 == 1, "R6 mode3 drops line", pulses - p0, 1);
    mode_i = 2'd2; coinc_i = 1'b1; step(2);
    p0 = pulses;
    mode_i = 2'd3; step(2); mode_i = 2'd0; step(2); mode_i = 2'd1; step(2);
    chk(pulses - p0 == 0, "R6 coincidence holds line", pulses - p0, 0);
    coinc_i = 1'b0;
  endtask

  task automatic t_display;
    int p0;
    mode_i = 2'd1; set_en(8'h10); disp_en_i = 1'b0;
    p0 = pulses; step(4);
    chk(pulses - p0 == 0, "R7 display off silent", pulses - p0, 0);
    disp_en_i = 1'b1; step();
    chk(irq_req_o == 1'b1, "R7 display on edge", irq_req_o, 1);
    step(2);
  endtask

  task automatic t_quirk;
    int c;
    coinc_i = 1'b0; quirk_hblank_i = 1'b0;
    mode_i = 2'd1; set_en(8'h00); disp_en_i = 1'b1; quirk_en_i = 1'b1; step(2);
    wr_count(8'h00, 3, c);
    chk(c == 1, "R8 spurious on write 0x00", c, 1);
    chk(stat_rd_o[6:3] == 4'h0, "R8 enables stay clear", stat_rd_o[6:3], 0);
    wr_count(8'h00, 3, c);
    chk(c == 1, "R8 repeat write fires again", c, 1);
    set_en(8'h10); disp_en_i = 1'b1; step(2);
    wr_count(8'h10, 3, c);
    chk(c == 0, "R9 held line blocks spurious", c, 0);
    mode_i = 2'd3; set_en(8'h00); disp_en_i = 1'b1; mode_i = 2'd0; step(2);
    wr_count(8'h00, 3, c);
    chk(c == 0, "R10 mode0 without option", c, 0);
    quirk_hblank_i = 1'b1; step();
    wr_count(8'h00, 3, c);
    chk(c == 1, "R10 mode0 with option", c, 1);
    mode_i = 2'd2; step(2);
    wr_count(8'h00, 3, c);
    chk(c == 0, "R10 mode2 never", c, 0);
    quirk_en_i = 1'b0; mode_i = 2'd1; step(2);
    wr_count(8'h00, 3, c);
    chk(c == 0, "R11 quirk disabled", c, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd0; coinc_i = 1'b0; disp_en_i = 1'b0;
    wr_en_i = 1'b0; wr_data_i = 8'h00; quirk_en_i = 1'b0; quirk_hblank_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_single_sources();
    t_blocking();
    t_all_enabled();
    t_display();
    t_quirk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule